// File: doc/BRIEF.md
# SPI Command Slave with Parallel Byte Readback

This block sits between a controlling processor and a bus-cycle tracker. Commands arrive as short serial frames on a four-wire SPI link. Each frame is one to four bytes long and is shifted in most significant bit first while the chip select is low. The first byte is an opcode, and the opcode fixes how many bytes the frame must carry. When the chip select rises on a frame of exactly that length, a small command state machine leaves its idle state. It then either fires a one-cycle write strobe with an address and a data byte, or updates one of three held control outputs: the video source, the audio source and USB power.

Reads take a separate path that is faster and bypasses SPI. An 8-bit parallel output shows the low or the high byte of the 16-bit address/data word currently captured by the tracker, chosen by a byte-select input. During the opcode byte of every frame, MISO returns a three-bit status snapshot to the controller. The serial inputs are asynchronous; they are brought into the system clock domain through two-flop synchronisers, and clock edges are found on the synchronised copy.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, vid_sel, aud_sel and usb_pwr are 0 (host video, host audio, power off), both strobes are low and miso is 0.
- R2: dout equals cap_word[15:8] when hbyte is 1 and cap_word[7:0] when hbyte is 0, with no clock delay.
- R3: The 4-byte frame {0x01, A[15:8], A[7:0], D} gives a single mem_wr_stb pulse with wr_addr = A and wr_data = D.
- R4: The 3-byte frame {0x02, P, D} gives a single io_wr_stb pulse with wr_addr = {8'h00, P} and wr_data = D.
- R5: The 2-byte frames {0x10, X}, {0x11, X} and {0x12, X} load bit 0 of X into vid_sel, aud_sel and usb_pwr respectively. Each output keeps its value until a later frame of its own opcode changes it.
- R6: Opcode 0x00 (NOP) and every opcode not listed in R3 to R5 form a 1-byte frame and change no output.
- R7: A frame is discarded if it ends with a partial byte or if its byte count differs from the length its opcode requires.
- R8: While the opcode byte is shifted, miso carries {ready, last_t, busack, 0, 0, 0, 0, 0} MSB first, sampled from the status inputs as chip select falls. miso is 0 on later bytes and while chip select is high.
- R9: With SAMPLE_RISE = 1, MOSI is sampled on rising SCLK edges; with SAMPLE_RISE = 0, on falling edges.
- R10: The write strobes last one clock, never coincide, and occur only after chip select has been high for at least two clocks. The held outputs change only under the same condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock (asynchronous) |
| mosi | input | 1 | SPI data in (asynchronous) |
| csn | input | 1 | SPI chip select, active low (asynchronous) |
| miso | output | 1 | SPI status data out |
| hbyte | input | 1 | Readback byte select: 1 = high byte |
| cap_word | input | 16 | Captured address/data word from the bus tracker |
| dout | output | 8 | Parallel readback byte |
| st_ready | input | 1 | Status: tracker idle |
| st_last_t | input | 1 | Status: last T-state of the cycle |
| st_busack | input | 1 | Status: bus granted |
| mem_wr_stb | output | 1 | One-cycle memory write command |
| io_wr_stb | output | 1 | One-cycle I/O write command |
| wr_addr | output | 16 | Address for a write command |
| wr_data | output | 8 | Data for a write command |
| vid_sel | output | 1 | Video source: 0 host, 1 local |
| aud_sel | output | 1 | Audio source: 0 host, 1 local |
| usb_pwr | output | 1 | USB VBUS power enable |

## Verification
The clocked properties assume that a chip-select rise is followed by a high period of several system clocks, and that SCLK half periods span several clocks, so that every edge passes through the synchronisers before the next one. The bench meets this by holding each SCLK level for eight clocks and by keeping chip select high for twenty clocks or more between frames. The status inputs are held steady around each chip-select fall.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter bit SAMPLE_RISE = 1'b1,
  parameter int BYTE_W      = 8,
  parameter int MAX_BYTES   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                mosi,
  input  logic                csn,
  output logic                miso,
  input  logic                hbyte,
  input  logic [2*BYTE_W-1:0] cap_word,
  output logic [BYTE_W-1:0]   dout,
  input  logic                st_ready,
  input  logic                st_last_t,
  input  logic                st_busack,
  output logic                mem_wr_stb,
  output logic                io_wr_stb,
  output logic [2*BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                vid_sel,
  output logic                aud_sel,
  output logic                usb_pwr
);
  localparam int FRAME_W = (MAX_BYTES - 1) * BYTE_W;
  localparam int BIT_CW  = $clog2(BYTE_W);
  localparam logic [7:0] OP_MEMWR = 8'h01, OP_IOWR = 8'h02,
                         OP_VID = 8'h10, OP_AUD = 8'h11, OP_USB = 8'h12;

  typedef enum logic {C_IDLE, C_RUN} cst_t;

  logic sclk_m, sclk_s, sclk_d, mosi_m, mosi_s, csn_m, csn_s, csn_d;
  logic [BIT_CW-1:0]  bitcnt;
  logic [2:0]         nbytes;
  logic [7:0]         op, run_op;
  logic [FRAME_W-1:0] frame;
  logic [2:0]         stat_q;
  logic               run_bit;
  cst_t               state;

  function automatic logic [2:0] op_len(input logic [7:0] o);
    case (o)
      OP_MEMWR:              op_len = 3'd4;
      OP_IOWR:               op_len = 3'd3;
      OP_VID, OP_AUD, OP_USB: op_len = 3'd2;
      default:               op_len = 3'd1;
    endcase
  endfunction

  wire smp      = SAMPLE_RISE ? (sclk_s & ~sclk_d) : (~sclk_s & sclk_d);
  wire cs_rise  = csn_s & ~csn_d;
  wire byte_end = (bitcnt == BIT_CW'(BYTE_W - 1));
  wire frame_ok = cs_rise && (bitcnt == '0) && (nbytes != 3'd0) && (nbytes == op_len(op));

  assign dout       = hbyte ? cap_word[2*BYTE_W-1:BYTE_W] : cap_word[BYTE_W-1:0];
  assign miso       = ~csn_s & (nbytes == 3'd0) & (bitcnt < BIT_CW'(3)) & stat_q[2'd2 - bitcnt[1:0]];
  assign mem_wr_stb = (state == C_RUN) && (run_op == OP_MEMWR);
  assign io_wr_stb  = (state == C_RUN) && (run_op == OP_IOWR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {sclk_m, sclk_s, sclk_d} <= {3{~SAMPLE_RISE}};
      {mosi_m, mosi_s}         <= 2'b00;
      {csn_m, csn_s, csn_d}    <= 3'b111;
    end else begin
      {sclk_m, sclk_s, sclk_d} <= {sclk, sclk_m, sclk_s};
      {mosi_m, mosi_s}         <= {mosi, mosi_m};
      {csn_m, csn_s, csn_d}    <= {csn, csn_m, csn_s};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0;
      nbytes <= '0;
      op     <= '0;
      frame  <= '0;
      stat_q <= '0;
    end else if (csn_s) begin
      bitcnt <= '0;
      nbytes <= '0;
      stat_q <= {st_ready, st_last_t, st_busack};
    end else if (smp) begin
      frame  <= {frame[FRAME_W-2:0], mosi_s};
      bitcnt <= bitcnt + 1'b1;
      if (byte_end) begin
        if (nbytes == 3'd0) op <= {frame[BYTE_W-2:0], mosi_s};
        if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= C_IDLE;
      run_op  <= '0;
      run_bit <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      vid_sel <= 1'b0;
      aud_sel <= 1'b0;
      usb_pwr <= 1'b0;
    end else if (state == C_IDLE) begin
      if (frame_ok) begin
        state   <= C_RUN;
        run_op  <= op;
        run_bit <= frame[0];
        if (op == OP_MEMWR) begin
          wr_addr <= frame[FRAME_W-1:BYTE_W];
          wr_data <= frame[BYTE_W-1:0];
        end else if (op == OP_IOWR) begin
          wr_addr <= {{BYTE_W{1'b0}}, frame[2*BYTE_W-1:BYTE_W]};
          wr_data <= frame[BYTE_W-1:0];
        end
      end
    end else begin
      state <= C_IDLE;
      case (run_op)
        OP_VID:  vid_sel <= run_bit;
        OP_AUD:  aud_sel <= run_bit;
        OP_USB:  usb_pwr <= run_bit;
        default: ;
      endcase
    end
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic csn,
  input logic miso,
  input logic mem_wr_stb,
  input logic io_wr_stb,
  input logic vid_sel,
  input logic aud_sel,
  input logic usb_pwr
);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr_stb, io_wr_stb}));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_stb || io_wr_stb) |=> !(mem_wr_stb || io_wr_stb));

  assert_strobe_after_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_stb || io_wr_stb) |-> ($past(csn, 1) && $past(csn, 2)));

  assert_hold_selects_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({vid_sel, aud_sel, usb_pwr}) |-> ($past(csn, 1) && $past(csn, 2) && $past(csn, 3)));

  assert_miso_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn, 1) && $past(csn, 2)) |-> !miso);
endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn(csn), .miso(miso),
  .mem_wr_stb(mem_wr_stb), .io_wr_stb(io_wr_stb),
  .vid_sel(vid_sel), .aud_sel(aud_sel), .usb_pwr(usb_pwr)
);

// File: tb/spi_cmd_slave_tb.sv
`timescale 1ns/1ps
module spi_cmd_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1, hbyte = 1'b0;
  logic [15:0] cap_word = '0;
  logic st_ready = 1'b0, st_last_t = 1'b0, st_busack = 1'b0;
  logic miso, mem_wr_stb, io_wr_stb, vid_sel, aud_sel, usb_pwr;
  logic [7:0] dout, wr_data;
  logic [15:0] wr_addr;
  logic f_miso, f_mem, f_io, f_vid, f_aud, f_usb;
  logic [7:0] f_dout, f_data;
  logic [15:0] f_addr;

  int total = 0, bad = 0;
  int mem_cnt = 0, io_cnt = 0, f_mem_cnt = 0;
  logic [15:0] last_addr;
  logic [7:0] last_data;
  logic [7:0] miso_op, miso_next;
  bit done = 0;

  always #4 clk = ~clk;

  spi_cmd_slave #(.SAMPLE_RISE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .csn(csn), .miso(miso),
    .hbyte(hbyte), .cap_word(cap_word), .dout(dout),
    .st_ready(st_ready), .st_last_t(st_last_t), .st_busack(st_busack),
    .mem_wr_stb(mem_wr_stb), .io_wr_stb(io_wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .vid_sel(vid_sel), .aud_sel(aud_sel), .usb_pwr(usb_pwr));

  spi_cmd_slave #(.SAMPLE_RISE(1'b0)) u_dut_fall (
    .clk(clk), .rst_n(rst_n), .sclk(~sclk), .mosi(mosi), .csn(csn), .miso(f_miso),
    .hbyte(hbyte), .cap_word(cap_word), .dout(f_dout),
    .st_ready(st_ready), .st_last_t(st_last_t), .st_busack(st_busack),
    .mem_wr_stb(f_mem), .io_wr_stb(f_io), .wr_addr(f_addr), .wr_data(f_data),
    .vid_sel(f_vid), .aud_sel(f_aud), .usb_pwr(f_usb));

  always @(negedge clk) begin
    if (mem_wr_stb) begin mem_cnt++; last_addr = wr_addr; last_data = wr_data; end
    if (io_wr_stb)  begin io_cnt++;  last_addr = wr_addr; last_data = wr_data; end
    if (f_mem) f_mem_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_send(input logic [31:0] bits, input int nbits);
    mem_cnt = 0; io_cnt = 0; f_mem_cnt = 0;
    miso_op = '0; miso_next = '0;
    @(negedge clk); csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[31 - i];
      repeat (HALF) @(negedge clk);
      if (i < 8) miso_op = {miso_op[6:0], miso};
      else if (i < 16) miso_next = {miso_next[6:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 vid_sel", vid_sel, 0);
    check("R1 aud_sel", aud_sel, 0);
    check("R1 usb_pwr", usb_pwr, 0);
    check("R1 strobes", {mem_wr_stb, io_wr_stb}, 0);
    check("R1 miso", miso, 0);
  endtask

  task automatic t_readback;
    cap_word = 16'hBEEF; hbyte = 1'b1; #1;
    check("R2 high byte", dout, 8'hBE);
    hbyte = 1'b0; #1;
    check("R2 low byte", dout, 8'hEF);
    cap_word = 16'h0180; #1;
    check("R2 low byte 2", dout, 8'h80);
    hbyte = 1'b1; #1;
    check("R2 high byte 2", dout, 8'h01);
  endtask

  task automatic t_memwr;
    spi_send(32'h0112345A, 32);
    check("R3 mem strobe count", mem_cnt, 1);
    check("R3 io strobe none", io_cnt, 0);
    check("R3 addr", last_addr, 16'h1234);
    check("R3 data", last_data, 8'h5A);
    check("R9 falling instance mem strobe", f_mem_cnt, 1);
    check("R9 falling instance addr", f_addr, 16'h1234);
  endtask

  task automatic t_iowr;
    spi_send(32'h027FC300, 24);
    check("R4 io strobe count", io_cnt, 1);
    check("R4 mem strobe none", mem_cnt, 0);
    check("R4 addr", last_addr, 16'h007F);
    check("R4 data", last_data, 8'hC3);
  endtask

  task automatic t_selects;
    spi_send(32'h10010000, 16);
    check("R5 vid on", vid_sel, 1);
    check("R9 falling instance vid", f_vid, 1);
    spi_send(32'h11030000, 16);
    check("R5 aud on", aud_sel, 1);
    spi_send(32'h12FF0000, 16);
    check("R5 usb on", usb_pwr, 1);
    spi_send(32'h10000000, 16);
    check("R5 vid off", vid_sel, 0);
    check("R5 aud held", aud_sel, 1);
    check("R5 usb held", usb_pwr, 1);
  endtask

  task automatic t_nop;
    spi_send(32'h00000000, 8);
    check("R6 nop no strobe", mem_cnt + io_cnt, 0);
    check("R6 nop selects", {vid_sel, aud_sel, usb_pwr}, 3'b011);
    spi_send(32'h55000000, 8);
    check("R6 undefined no strobe", mem_cnt + io_cnt, 0);
    check("R6 undefined selects", {vid_sel, aud_sel, usb_pwr}, 3'b011);
  endtask

  task automatic t_drop;
    spi_send(32'h01123400, 24);
    check("R7 short frame dropped", mem_cnt, 0);
    spi_send(32'h0112345A, 27);
    check("R7 partial byte dropped", mem_cnt, 0);
    spi_send(32'h10010100, 24);
    check("R7 long frame dropped", vid_sel, 0);
    spi_send(32'h11000000, 12);
    check("R7 partial select dropped", aud_sel, 1);
  endtask

  task automatic t_status;
    st_ready = 1'b1; st_last_t = 1'b0; st_busack = 1'b1;
    spi_send(32'h00000000, 16);
    check("R8 status byte", miso_op, 8'hA0);
    check("R8 later byte zero", miso_next, 8'h00);
    st_ready = 1'b0; st_last_t = 1'b1; st_busack = 1'b0;
    spi_send(32'h00000000, 8);
    check("R8 status byte 2", miso_op, 8'h40);
    check("R8 idle miso", miso, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_readback;
    t_memwr;
    t_iowr;
    t_selects;
    t_nop;
    t_drop;
    t_status;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule